// File: doc/BRIEF.md
# Receive Frame Status Queue

This block sits beside a bit-oriented synchronous receiver and keeps, for each completed frame, the error and residue status together with the frame's byte count. The host can then collect the results of several back-to-back frames at its own pace. A one-cycle frame-end strobe captures the live residue, overrun and CRC-error bits and the live 14-bit byte count as one queue entry. The all-sent, parity and end-of-frame bits are never queued. They always show their live value.

The host reads through a 2-bit register address and a read strobe, in a fixed order. It reads the count-high register first, then the count-low register if it needs it, then the status register. The count-high read records whether an entry is waiting and arms exactly one pop. The status read that follows returns the queued bits of the head entry and releases that entry. If the count-high read found the queue empty, the status read returns the live bits instead. An enable input switches queueing on. Dropping it empties the queue and clears the overflow flag.

Top module: `rx_frame_status_queue`

## Requirements
- R1: After synchronous reset, `rd_data_o` is 0x00, and a count-high read (address 2) returns 0x00.
- R2: While `fifo_en_i` is 0, frame-end strobes store nothing, a count-high read returns 0x00, and a status read returns only live bits.
- R3: With `fifo_en_i` at 1, each `frame_end_i` pulse stores one entry. Entries come out in arrival order. A count-high read (address 2) returns bit 6 = 1 and bits 5:0 = count[13:8] of the head entry. A count-low read (address 1) returns count[7:0] of the head entry.
- R4: The status byte (address 0) is laid out as: bit 0 all-sent, bits 3:1 residue, bit 4 parity, bit 5 overrun, bit 6 CRC error, bit 7 end-of-frame. All-sent, parity and end-of-frame are always the live inputs.
- R5: The residue, overrun and CRC bits of a status read come from the head entry only when the most recent count-high read found the queue non-empty. Otherwise they come from the live inputs.
- R6: An armed status read releases exactly one entry. A further status read without a new count-high read returns live bits and releases nothing.
- R7: A status read while the queue is empty does not underflow. A later frame is stored and read back intact, and the queue is then empty again.
- R8: With the queue empty, a count-low read returns 0x00 and bits 5:0 of a count-high read are 0.
- R9: A frame-end while 10 entries are held sets bit 7 of the count-high register and the entry is dropped. The flag stays set until `fifo_en_i` goes low. Taking `fifo_en_i` low also discards all held entries.
- R10: A frame-end and an armed status read in the same cycle are both honoured. The read returns the old head and the new frame is kept.
- R11: A read of address 3 returns `fifo_en_i` in bit 2, with all other bits 0.
- R12: `rd_data_o` is registered. It takes the addressed value at the clock edge where `rd_stb_i` is high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | Queue mode enable; low clears queue and overflow flag |
| frame_end_i | input | 1 | One-cycle end-of-frame strobe |
| live_res_i | input | 3 | Live residue bits |
| live_overrun_i | input | 1 | Live overrun bit |
| live_crc_err_i | input | 1 | Live CRC error bit |
| live_all_sent_i | input | 1 | Live all-sent bit (never queued) |
| live_parity_i | input | 1 | Live parity bit (never queued) |
| live_eof_i | input | 1 | Live end-of-frame bit (never queued) |
| live_count_i | input | 14 | Live frame byte count |
| rd_addr_i | input | 2 | Register select: 0 status, 1 count-low, 2 count-high, 3 mode |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | 8 | Registered read data |

## Verification
The assertions check the following on every cycle:
- occupancy never exceeds the depth;
- a disabled queue is empty with its overflow flag clear;
- the overflow flag stays set while enabled, and a push into a full queue raises it;
- an armed pop is never pending on an empty queue;
- the read data holds when no read is strobed.

Only the bench scenarios can show the rest:
- that entries come back in order with their exact count and status bits;
- that live bypass bits mix correctly with queued bits;
- that repeated or empty status reads release nothing;
- that a push and a pop in the same cycle keep the right entry.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {
    REG_STAT   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_MODE   = 2'd3
  } fsq_reg_e;

  // status bits that travel through the queue
  typedef struct packed {
    logic [2:0] residue;
    logic       overrun;
    logic       crc_err;
  } fsq_flags_t;

  localparam int FLAGS_W = $bits(fsq_flags_t);
endpackage

// File: rtl/fsq_store.sv
module fsq_store #(
  parameter int DEPTH  = 10,
  parameter int DATA_W = 19,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl #(
  parameter int DEPTH = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             we,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             empty,
  output logic             ovf
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ;
  logic             full, push_ok, pop_ok, drop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (occ == FULL_OCC);
  assign empty   = (occ == '0);
  assign push_ok = en && push_req && !full;
  assign drop    = en && push_req && full;
  assign pop_ok  = en && pop_req && !empty;
  assign we      = push_ok;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end

  assert_occ_bound_R9: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_OCC);
  assert_disabled_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (empty && !ovf));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (en && ovf) |=> ovf);
  assert_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    (en && push_req && full) |=> ovf);
endmodule

// File: rtl/fsq_readmux.sv
module fsq_readmux
  import fsq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rd_stb,
  input  logic [1:0]       rd_addr,
  input  logic             empty,
  input  logic             ovf,
  input  fsq_flags_t       head_flags,
  input  logic [CNT_W-1:0] head_count,
  input  fsq_flags_t       live_flags,
  input  logic             live_all_sent,
  input  logic             live_parity,
  input  logic             live_eof,
  output logic             pop_req,
  output logic [7:0]       rd_data
);
  localparam int HI_W = CNT_W - 8;

  logic       armed;
  logic       rd_hi, rd_st;
  fsq_flags_t sel_flags;
  logic [5:0] hi_bits;
  logic [7:0] nxt;

  assign rd_hi   = rd_stb && (rd_addr == REG_CNT_HI);
  assign rd_st   = rd_stb && (rd_addr == REG_STAT);
  assign pop_req = rd_st && armed;

  // count-high read arms one pop; status read consumes it
  always_ff @(posedge clk) begin
    if (rst || !en)  armed <= 1'b0;
    else if (rd_hi)  armed <= !empty;
    else if (rd_st)  armed <= 1'b0;
  end

  always_comb begin
    sel_flags = armed ? head_flags : live_flags;
    hi_bits   = '0;
    if (!empty) hi_bits[HI_W-1:0] = head_count[CNT_W-1:8];
    case (fsq_reg_e'(rd_addr))
      REG_STAT:   nxt = {live_eof, sel_flags.crc_err, sel_flags.overrun,
                         live_parity, sel_flags.residue, live_all_sent};
      REG_CNT_LO: nxt = empty ? 8'h00 : head_count[7:0];
      REG_CNT_HI: nxt = {ovf, !empty, hi_bits};
      default:    nxt = {5'b0, en, 2'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= nxt;
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
  assert_arm_has_data_R5: assert property (@(posedge clk) disable iff (rst)
    armed |-> !empty);
endmodule

// File: rtl/rx_frame_status_queue.sv
module rx_frame_status_queue
  import fsq_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en_i,
  input  logic             frame_end_i,
  input  logic [2:0]       live_res_i,
  input  logic             live_overrun_i,
  input  logic             live_crc_err_i,
  input  logic             live_all_sent_i,
  input  logic             live_parity_i,
  input  logic             live_eof_i,
  input  logic [CNT_W-1:0] live_count_i,
  input  logic [1:0]       rd_addr_i,
  input  logic             rd_stb_i,
  output logic [7:0]       rd_data_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int DATA_W = FLAGS_W + CNT_W;

  fsq_flags_t        live_flags, head_flags;
  logic [DATA_W-1:0] wdata, rdata;
  logic [CNT_W-1:0]  head_count;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              we, empty, ovf, pop_req;

  assign live_flags = '{residue: live_res_i, overrun: live_overrun_i,
                        crc_err: live_crc_err_i};
  assign wdata = {live_flags, live_count_i};
  assign {head_flags, head_count} = rdata;

  fsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .en(fifo_en_i), .push_req(frame_end_i),
    .pop_req(pop_req), .we(we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .empty(empty), .ovf(ovf)
  );

  fsq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(we), .waddr(wr_ptr), .wdata(wdata),
    .raddr(rd_ptr), .rdata(rdata)
  );

  fsq_readmux #(.CNT_W(CNT_W)) u_rmux (
    .clk(clk), .rst(rst), .en(fifo_en_i), .rd_stb(rd_stb_i),
    .rd_addr(rd_addr_i), .empty(empty), .ovf(ovf),
    .head_flags(head_flags), .head_count(head_count),
    .live_flags(live_flags), .live_all_sent(live_all_sent_i),
    .live_parity(live_parity_i), .live_eof(live_eof_i),
    .pop_req(pop_req), .rd_data(rd_data_o)
  );

  assert_empty_lo_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && rd_addr_i == REG_CNT_LO && empty) |=> rd_data_o == 8'h00);
endmodule

// File: tb/rx_frame_status_queue_bench.sv
module rx_frame_status_queue_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, fe = 1'b0, stb = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [2:0] l_res = '0;
  logic l_ovr = 0, l_crc = 0, l_as = 0, l_par = 0, l_eof = 0;
  logic [13:0] l_cnt = '0;
  logic [7:0] rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_status_queue u_rx_frame_status_queue (
    .clk(clk), .rst(rst), .fifo_en_i(en), .frame_end_i(fe),
    .live_res_i(l_res), .live_overrun_i(l_ovr), .live_crc_err_i(l_crc),
    .live_all_sent_i(l_as), .live_parity_i(l_par), .live_eof_i(l_eof),
    .live_count_i(l_cnt), .rd_addr_i(addr), .rd_stb_i(stb), .rd_data_o(rdata)
  );

  function automatic logic [7:0] sb(logic a, logic [2:0] r, logic p,
                                    logic o, logic c, logic e);
    return {e, c, o, p, r, a};
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: compares each read result one edge after its strobe
  initial forever begin
    @(posedge clk);
    if (!rst && stb) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk(rdata, 8'hxx, "unexpected read");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // driver tasks: called at a negedge, return at a negedge
  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    addr = a; stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic set_q(logic [2:0] r, logic o, logic c, logic [13:0] n);
    l_res = r; l_ovr = o; l_crc = c; l_cnt = n;
  endtask

  task automatic push(logic [2:0] r, logic o, logic c, logic [13:0] n);
    set_q(r, o, c, n); fe = 1'b1;
    @(negedge clk);
    fe = 1'b0;
  endtask

  task automatic rd_push(logic [1:0] a, logic [7:0] e, string tag,
                         logic [2:0] r, logic o, logic c, logic [13:0] n);
    set_q(r, o, c, n); fe = 1'b1;
    addr = a; stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    fe = 1'b0; stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [13:0] ca, cb, cc;
    ca = 14'h1A5C; cb = 14'h0033; cc = 14'h2001;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdata, 8'h00, "R1 reset data");
    rd(2'd2, 8'h00, "R1 count-high after reset");
    rd(2'd3, 8'h00, "R11 mode with enable low");

    // disabled: frame-end ignored, status is live
    l_as = 1; l_par = 0; l_eof = 1;
    push(3'd6, 1, 1, 14'h0ABC);
    rd(2'd2, 8'h00, "R2 nothing stored while disabled");
    rd(2'd0, sb(1, 3'd6, 0, 1, 1, 1), "R2 live status while disabled");

    en = 1'b1;
    @(negedge clk);
    rd(2'd3, 8'h04, "R11 mode with enable high");
    push(3'd5, 1, 0, ca);
    push(3'd2, 0, 1, cb);
    set_q(3'd7, 0, 0, 14'h0000);
    rd(2'd2, {2'b01, ca[13:8]}, "R3 first entry high");
    rd(2'd1, ca[7:0], "R3 first entry low");
    rd(2'd0, sb(1, 3'd5, 0, 1, 0, 1), "R4 R5 queued status of first entry");
    rd(2'd0, sb(1, 3'd7, 0, 0, 0, 1), "R6 repeated status read is live");
    rd(2'd2, {2'b01, cb[13:8]}, "R6 second entry now head");
    rd(2'd1, cb[7:0], "R3 second entry low");
    l_par = 1;
    rd(2'd0, sb(1, 3'd2, 1, 0, 1, 1), "R4 queued status with live parity");
    rd(2'd2, 8'h00, "R8 empty count-high");
    rd(2'd1, 8'h00, "R8 empty count-low");
    rd(2'd0, sb(1, 3'd7, 1, 0, 0, 1), "R5 status after empty check is live");
    rd(2'd0, sb(1, 3'd7, 1, 0, 0, 1), "R7 status read on empty queue");
    push(3'd1, 0, 0, cc);
    set_q(3'd7, 0, 0, 14'h0000);
    rd(2'd2, {2'b01, cc[13:8]}, "R7 entry intact after empty read");
    rd(2'd1, cc[7:0], "R7 entry low intact");
    rd(2'd0, sb(1, 3'd1, 1, 0, 0, 1), "R7 entry status intact");
    rd(2'd2, 8'h00, "R7 queue empty again");

    // hold check
    repeat (3) @(negedge clk);
    chk(rdata, 8'h00, "R12 data holds without strobe");
    rd(2'd3, 8'h04, "R12 new read updates data");
    repeat (2) @(negedge clk);
    chk(rdata, 8'h04, "R12 data holds after read");

    // overflow
    for (int i = 0; i < 10; i++) push(3'd0, 0, 0, 14'(i + 1));
    push(3'd4, 1, 1, 14'h3FFF);
    set_q(3'd3, 0, 0, 14'h0000);
    for (int i = 0; i < 10; i++) begin
      rd(2'd2, 8'hC0, "R9 overflow flag with data");
      rd(2'd1, 8'(i + 1), "R9 stored entries in order");
      rd(2'd0, sb(1, 3'd0, 1, 0, 0, 1), "R9 stored entry status");
    end
    rd(2'd2, 8'h80, "R9 dropped entry absent, flag kept");
    en = 1'b0; @(negedge clk); en = 1'b1; @(negedge clk);
    rd(2'd2, 8'h00, "R9 flag cleared by enable toggle");
    push(3'd2, 0, 0, 14'h0155);
    en = 1'b0; @(negedge clk); en = 1'b1; @(negedge clk);
    rd(2'd2, 8'h00, "R9 entries discarded by enable toggle");

    // simultaneous push and pop
    push(3'd3, 1, 0, 14'h0100);
    set_q(3'd0, 0, 0, 14'h0000);
    rd(2'd2, 8'h41, "R10 head before combined cycle");
    rd_push(2'd0, sb(1, 3'd3, 1, 1, 0, 1), "R10 pop returns old head",
            3'd6, 0, 1, 14'h0200);
    set_q(3'd0, 0, 0, 14'h0000);
    rd(2'd2, 8'h42, "R10 new entry kept");
    rd(2'd1, 8'h00, "R10 new entry low");
    rd(2'd0, sb(1, 3'd6, 1, 0, 1, 1), "R10 new entry status");
    rd(2'd2, 8'h00, "R10 queue empty after both");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "queue drained");
    summary();
  end
endmodule